// File: doc/BRIEF.md
# Flash Write-Enable and Block-Protect Guard

This block keeps the status byte of a serial flash and decides whether each write request may run. A command decoder upstream hands it one strobe per finished command, carrying the opcode byte, the 20-bit target address, the number of whole data bytes that followed the address, the first data byte, and a flag saying that the command ended on a byte boundary. The block answers one cycle later with a one-cycle grant or deny pulse for erase, program and status-write requests. It also keeps the write-enable latch, the protect level and the status-lock bit, and it runs the busy interval of an accepted operation.

The busy interval is counted in ticks from an external time base. The number of ticks for each operation type is a parameter, so a bench can use short intervals. The nonvolatile bits are ordinary registers with a parameter for their reset value.

Top module: `flash_guard_ctrl`

## Requirements
- R1: `status` bit 0 is busy, bit 1 is the write-enable latch, bits 4:2 are the protect level, bits 6:5 read 0 and bit 7 is the status-lock bit. With default parameters `status` is 8'h00 after reset.
- R2: A byte-aligned opcode 8'h06 sets the write-enable latch and 8'h04 clears it. The new value shows in the cycle after the strobe, and these opcodes pulse neither `grant` nor `deny`.
- R3: Opcodes 8'h01, 8'h20, 8'hD7, 8'hD8, 8'hC7 and 8'h02 are write requests. A write request is granted only if the command is byte-aligned, the latch is 1, `busy` is 0 and no other rule refuses it. A denied request leaves the latch unchanged.
- R4: Protect level L protects a region at the top of the 1 MB space. For L = 1, 2, 3 and 4 the region starts at 20'hF0000, 20'hE0000, 20'hC0000 and 20'h80000. Levels 5 to 7 protect all of it and level 0 protects nothing. An erase or program whose range touches the protected region is denied.
- R5: Chip erase (8'hC7) is denied at any protect level other than 0.
- R6: A status write is denied when bit 7 is 1 and `wp_n` is 0, and `wp_n` high never blocks it. When granted, data bits 7 and 4:2 are copied into the status byte at once, and data bits 6:5 and 1:0 are dropped.
- R7: A status write whose data count is not exactly 1 is denied. A page program (8'h02) with a data count of 0 is denied.
- R8: Small-sector erase (8'h20 or 8'hD7) covers the 4 KB block chosen by address bits 19:12. Sector erase (8'hD8) covers the 64 KB block chosen by address bits 19:16. Page program covers the 256-byte page chosen by address bits 19:8.
- R9: After a grant, `busy` is 1 from the next cycle. It falls, and the latch is cleared in the same cycle, after the N-th `tick` pulse, where N is the tick count for that operation type.
- R10: `grant` and `deny` are one-cycle pulses in the cycle after `cmd_valid`. Only one of them is high at a time. An unknown opcode pulses neither and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe: a finished command is presented |
| cmd_code | input | 8 | Opcode byte |
| cmd_addr | input | 20 | Target byte address |
| cmd_aligned | input | 1 | Command ended on a byte boundary |
| cmd_data_cnt | input | 3 | Whole data bytes after the address, saturating at 7 |
| cmd_data | input | 8 | First data byte |
| wp_n | input | 1 | Write-protect pin, active low |
| tick | input | 1 | Time-base pulse for the busy interval |
| status | output | 8 | Status byte |
| busy | output | 1 | An accepted operation is in progress |
| grant | output | 1 | Write request accepted |
| deny | output | 1 | Write request refused |

## Verification
A wrong latch or protect level shows on `status` in the cycle after the command that corrupted it. It shows again as a wrong verdict on the very next write request, which the bench compares with a model built from the rules above. A wrong busy count shows as `busy` falling one or more ticks early or late, which the bench sees because it samples `status` after every tick. Random mixes of opcodes, addresses, data counts, alignment and pin levels are interleaved with directed requests at each protect boundary.

// File: rtl/flash_guard_pkg.sv
// Package: opcode values, operation classes and status byte layout shared by the guard.
// Assumes opcode values are fixed by the serial command set seen upstream.
package flash_guard_pkg;

    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRDI = 8'h04;
    localparam logic [7:0] OPC_SRW  = 8'h01;
    localparam logic [7:0] OPC_SSE0 = 8'h20;
    localparam logic [7:0] OPC_SSE1 = 8'hD7;
    localparam logic [7:0] OPC_SE   = 8'hD8;
    localparam logic [7:0] OPC_CE   = 8'hC7;
    localparam logic [7:0] OPC_PP   = 8'h02;

    // Writable (nonvolatile) bits of the status byte: lock bit 7, level bits 4:2.
    localparam logic [7:0] NV_MASK  = 8'h9C;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WREN,
        OP_WRDI,
        OP_SRW,
        OP_SSE,
        OP_SE,
        OP_CE,
        OP_PP
    } op_e;

endpackage

// File: rtl/guard_cmd_decode.sv
// Module: maps an opcode byte to an operation class.
// Assumes one opcode per strobe; unknown codes map to OP_NONE.
module guard_cmd_decode
    import flash_guard_pkg::*;
(
    input  logic [7:0] code,
    output op_e        op,
    output logic       is_write
);

    // Classify the opcode.
    always_comb begin
        unique case (code)
            OPC_WREN:           op = OP_WREN;
            OPC_WRDI:           op = OP_WRDI;
            OPC_SRW:            op = OP_SRW;
            OPC_SSE0, OPC_SSE1: op = OP_SSE;
            OPC_SE:             op = OP_SE;
            OPC_CE:             op = OP_CE;
            OPC_PP:             op = OP_PP;
            default:            op = OP_NONE;
        endcase
    end

    // Flag the classes that need a grant decision.
    always_comb begin
        is_write = (op == OP_SRW) || (op == OP_SSE) || (op == OP_SE) ||
                   (op == OP_CE)  || (op == OP_PP);
    end

endmodule

// File: rtl/guard_prot_window.sv
// Module: decides whether the range an operation touches overlaps the protected top region.
// Assumes protected regions are aligned to SEC_W and cover whole ranges of every op size.
module guard_prot_window
    import flash_guard_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int SUB_W       = 12,
    parameter int SEC_W       = 16,
    parameter int PAGE_W      = 8,
    parameter int LVL_W       = 3,
    parameter int PART_LEVELS = 4
) (
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LVL_W-1:0]  level,
    output logic              blocked
);

    localparam int          NUM_LVL   = 1 << LVL_W;
    localparam logic [ADDR_W:0] FULL_SPAN = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [ADDR_W:0] ONE_X     = {{ADDR_W{1'b0}}, 1'b1};

    logic [ADDR_W:0] bound [NUM_LVL];
    logic [ADDR_W:0] span;
    logic [ADDR_W:0] base_x;
    logic [ADDR_W:0] end_x;

    // Lowest protected address per level: all open, partial top slices, or all protected.
    for (genvar g = 0; g < NUM_LVL; g++) begin : g_bound
        if (g == 0) begin : g_open
            assign bound[g] = FULL_SPAN;
        end else if (g <= PART_LEVELS) begin : g_part
            assign bound[g] = FULL_SPAN - (ONE_X << (SEC_W + g - 1));
        end else begin : g_all
            assign bound[g] = '0;
        end
    end

    // Size of the range touched by this operation class.
    always_comb begin
        unique case (op)
            OP_SSE:  span = ONE_X << SUB_W;
            OP_SE:   span = ONE_X << SEC_W;
            OP_PP:   span = ONE_X << PAGE_W;
            OP_CE:   span = FULL_SPAN;
            default: span = '0;
        endcase
    end

    // Aligned start and exclusive end of the touched range.
    always_comb begin
        base_x = {1'b0, addr} & ~(span - ONE_X);
        end_x  = base_x + span;
    end

    // Blocked when the range reaches past the lowest protected address.
    always_comb begin
        if (span == '0) begin
            blocked = 1'b0;
        end else begin
            blocked = end_x > bound[level];
        end
    end

endmodule

// File: rtl/guard_busy_timer.sv
// Module: counts ticks of an accepted operation and flags its completion.
// Assumes every tick count parameter is at least 1 and start never coincides with busy.
module guard_busy_timer
    import flash_guard_pkg::*;
#(
    parameter int T_SSE = 3,
    parameter int T_SE  = 4,
    parameter int T_CE  = 6,
    parameter int T_PP  = 2,
    parameter int T_SRW = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  op_e  op,
    input  logic tick,
    output logic busy,
    output logic done
);

    function automatic int max_ticks();
        int m;
        m = T_SSE;
        if (T_SE  > m) m = T_SE;
        if (T_CE  > m) m = T_CE;
        if (T_PP  > m) m = T_PP;
        if (T_SRW > m) m = T_SRW;
        return m;
    endfunction

    localparam int CNT_W = $clog2(max_ticks() + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_val;

    // Tick count for the operation being started.
    always_comb begin
        unique case (op)
            OP_SSE:  load_val = CNT_W'(T_SSE);
            OP_SE:   load_val = CNT_W'(T_SE);
            OP_CE:   load_val = CNT_W'(T_CE);
            OP_PP:   load_val = CNT_W'(T_PP);
            OP_SRW:  load_val = CNT_W'(T_SRW);
            default: load_val = '0;
        endcase
    end

    // Load on start, count down one per tick while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Busy while ticks remain; done on the last tick.
    always_comb begin
        busy = cnt_q != '0;
        done = tick && (cnt_q == CNT_W'(1));
    end

    AST_BUSY_FALLS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick)); // R9

endmodule

// File: rtl/flash_guard_ctrl.sv
// Module: status byte keeper and write-permission guard for a serial flash.
// Assumes one command strobe per finished command, presented only after the command ended.
module flash_guard_ctrl
    import flash_guard_pkg::*;
#(
    parameter int         ADDR_W      = 20,
    parameter int         SUB_W       = 12,
    parameter int         SEC_W       = 16,
    parameter int         PAGE_W      = 8,
    parameter int         PART_LEVELS = 4,
    parameter int         T_SSE       = 3,
    parameter int         T_SE        = 4,
    parameter int         T_CE        = 6,
    parameter int         T_PP        = 2,
    parameter int         T_SRW       = 5,
    parameter logic [7:0] RST_NV      = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_aligned,
    input  logic [2:0]        cmd_data_cnt,
    input  logic [7:0]        cmd_data,
    input  logic              wp_n,
    input  logic              tick,
    output logic [7:0]        status,
    output logic              busy,
    output logic              grant,
    output logic              deny
);

    localparam int LVL_W = 3;

    op_e        op;
    logic       is_write;
    logic       range_blocked;
    logic       op_done;
    logic       count_ok;
    logic       srw_locked;
    logic       permit;
    logic       accept;
    logic       refuse;
    logic       wel_q;
    logic [7:0] nv_q;
    logic       grant_q;
    logic       deny_q;

    guard_cmd_decode u_decode (
        .code     (cmd_code),
        .op       (op),
        .is_write (is_write)
    );

    guard_prot_window #(
        .ADDR_W      (ADDR_W),
        .SUB_W       (SUB_W),
        .SEC_W       (SEC_W),
        .PAGE_W      (PAGE_W),
        .LVL_W       (LVL_W),
        .PART_LEVELS (PART_LEVELS)
    ) u_window (
        .op      (op),
        .addr    (cmd_addr),
        .level   (nv_q[4:2]),
        .blocked (range_blocked)
    );

    guard_busy_timer #(
        .T_SSE (T_SSE),
        .T_SE  (T_SE),
        .T_CE  (T_CE),
        .T_PP  (T_PP),
        .T_SRW (T_SRW)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .op    (op),
        .tick  (tick),
        .busy  (busy),
        .done  (op_done)
    );

    // Data-count rule per operation class.
    always_comb begin
        unique case (op)
            OP_SRW:  count_ok = cmd_data_cnt == 3'd1;
            OP_PP:   count_ok = cmd_data_cnt != 3'd0;
            default: count_ok = 1'b1;
        endcase
    end

    // Combine every acceptance rule into one verdict.
    always_comb begin
        srw_locked = (op == OP_SRW) && nv_q[7] && !wp_n;
        permit     = cmd_aligned && wel_q && !busy && count_ok &&
                     !range_blocked && !srw_locked;
        accept     = cmd_valid && is_write && permit;
        refuse     = cmd_valid && is_write && !permit;
    end

    // Status registers, latch and verdict pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q   <= 1'b0;
            nv_q    <= RST_NV & NV_MASK;
            grant_q <= 1'b0;
            deny_q  <= 1'b0;
        end else begin
            grant_q <= accept;
            deny_q  <= refuse;
            if (op_done) begin
                wel_q <= 1'b0;
            end
            if (cmd_valid && cmd_aligned && (op == OP_WREN)) begin
                wel_q <= 1'b1;
            end
            if (cmd_valid && cmd_aligned && (op == OP_WRDI)) begin
                wel_q <= 1'b0;
            end
            if (accept && (op == OP_SRW)) begin
                nv_q <= cmd_data & NV_MASK;
            end
        end
    end

    // Assemble outputs.
    always_comb begin
        status = nv_q | {6'b0, wel_q, busy};
        grant  = grant_q;
        deny   = deny_q;
    end

    AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> ($past(wel_q) && !$past(busy))); // R3
    AST_DENY_HOLDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (deny && !$past(op_done)) |-> (wel_q == $past(wel_q))); // R3
    AST_LEVEL0_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (nv_q[4:2] == 3'd0)) |-> !range_blocked); // R4
    AST_CE_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && $past(op == OP_CE)) |-> ($past(nv_q[4:2]) == 3'd0)); // R5
    AST_SRW_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && $past(op == OP_SRW)) |-> ($past(wp_n) || !$past(nv_q[7]))); // R6
    AST_GRANT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> busy); // R9
    AST_DONE_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !(cmd_valid && (op == OP_WREN))) |=> !wel_q); // R9
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && deny)); // R10

endmodule

// File: tb/flash_guard_ctrl_bench.sv
module flash_guard_ctrl_bench;

    localparam int T_SSE = 3;
    localparam int T_SE  = 4;
    localparam int T_CE  = 6;
    localparam int T_PP  = 2;
    localparam int T_SRW = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic [19:0] cmd_addr = '0;
    logic        cmd_aligned = 1'b1;
    logic [2:0]  cmd_data_cnt = 3'd0;
    logic [7:0]  cmd_data = 8'h00;
    logic        wp_n = 1'b1;
    logic        tick = 1'b0;
    logic [7:0]  status;
    logic        busy;
    logic        grant;
    logic        deny;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference state built from the requirements.
    bit       m_wel = 0;
    bit [2:0] m_lvl = 0;
    bit       m_lock = 0;
    bit       m_busy = 0;
    int       m_left = 0;

    always #2 clk = ~clk;

    flash_guard_ctrl #(
        .T_SSE (T_SSE), .T_SE (T_SE), .T_CE (T_CE), .T_PP (T_PP), .T_SRW (T_SRW)
    ) u_flash_guard_ctrl (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_code (cmd_code),
        .cmd_addr (cmd_addr), .cmd_aligned (cmd_aligned), .cmd_data_cnt (cmd_data_cnt),
        .cmd_data (cmd_data), .wp_n (wp_n), .tick (tick), .status (status),
        .busy (busy), .grant (grant), .deny (deny)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit [7:0] exp_status();
        return {m_lock, 2'b00, m_lvl, m_wel, m_busy};
    endfunction

    function automatic bit is_wr(input bit [7:0] c);
        return c == 8'h01 || c == 8'h20 || c == 8'hD7 || c == 8'hD8 || c == 8'hC7 || c == 8'h02;
    endfunction

    function automatic int ticks_of(input bit [7:0] c);
        case (c)
            8'h20, 8'hD7: return T_SSE;
            8'hD8:        return T_SE;
            8'hC7:        return T_CE;
            8'h02:        return T_PP;
            default:      return T_SRW;
        endcase
    endfunction

    // Range protection per R4, R5, R8.
    function automatic bit prot_hit(input bit [7:0] c, input bit [19:0] a);
        int bound;
        int start;
        int size;
        if (m_lvl == 0) bound = 1 << 20;
        else if (m_lvl >= 5) bound = 0;
        else bound = (1 << 20) - (65536 << (m_lvl - 1));
        case (c)
            8'h20, 8'hD7: begin size = 4096;    start = int'(a[19:12]) << 12; end
            8'hD8:        begin size = 65536;   start = int'(a[19:16]) << 16; end
            8'h02:        begin size = 256;     start = int'(a[19:8]) << 8;   end
            8'hC7:        begin size = 1 << 20; start = 0;                    end
            default:      return 1'b0;
        endcase
        return (start + size) > bound;
    endfunction

    task automatic do_cmd(input bit [7:0] c, input bit [19:0] a, input bit [2:0] n,
                          input bit [7:0] d, input bit al, input bit wp, input string req);
        bit eg;
        bit ed;
        bit ok;
        eg = 0;
        ed = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_code = c; cmd_addr = a; cmd_data_cnt = n;
        cmd_data = d; cmd_aligned = al; wp_n = wp;
        if (is_wr(c)) begin
            ok = al && m_wel && !m_busy && !prot_hit(c, a);
            if (c == 8'h01) ok = ok && (n == 1) && !(m_lock && !wp);
            if (c == 8'h02) ok = ok && (n != 0);
            eg = ok;
            ed = !ok;
            if (ok) begin
                m_busy = 1;
                m_left = ticks_of(c);
                if (c == 8'h01) begin
                    m_lvl = d[4:2];
                    m_lock = d[7];
                end
            end
        end else if (al && c == 8'h06) begin
            m_wel = 1;
        end else if (al && c == 8'h04) begin
            m_wel = 0;
        end
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 0;
        chk({req, " grant"}, int'(grant), int'(eg));
        chk({req, " deny"}, int'(deny), int'(ed));
        chk({req, " status"}, int'(status), int'(exp_status()));
    endtask

    task automatic do_tick(input string req);
        @(negedge clk);
        tick = 1;
        if (m_busy) begin
            m_left--;
            if (m_left == 0) begin
                m_busy = 0;
                m_wel = 0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        tick = 0;
        chk({req, " status after tick"}, int'(status), int'(exp_status()));
        chk({req, " busy after tick"}, int'(busy), int'(m_busy));
    endtask

    task automatic drain(input string req);
        while (m_busy) do_tick(req);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset status", int'(status), 8'h00);
        chk("R10 reset grant", int'(grant), 0);
        chk("R10 reset deny", int'(deny), 0);

        do_cmd(8'h02, 20'h00100, 3'd1, 8'h00, 1, 1, "R3 program without latch");
        do_cmd(8'h06, 20'h0, 3'd0, 8'h00, 1, 1, "R2 set latch");
        do_cmd(8'h04, 20'h0, 3'd0, 8'h00, 1, 1, "R2 clear latch");
        do_cmd(8'h06, 20'h0, 3'd0, 8'h00, 0, 1, "R2 unaligned set ignored");
        do_cmd(8'h06, 20'h0, 3'd0, 8'h00, 1, 1, "R2 set latch again");
        do_cmd(8'h02, 20'h00100, 3'd1, 8'h00, 0, 1, "R3 unaligned program");
        do_cmd(8'h01, 20'h0, 3'd1, 8'hFF, 1, 1, "R6 status write masks reserved");
        do_cmd(8'h06, 20'h0, 3'd0, 8'h00, 1, 1, "R3 latch during busy");
        do_cmd(8'hD8, 20'h00000, 3'd0, 8'h00, 1, 1, "R3 request while busy");
        drain("R9 status write interval");
        do_cmd(8'h06, 20'h0, 3'd0, 8'h00, 1, 1, "R2 set latch");
        do_cmd(8'h01, 20'h0, 3'd1, 8'h04, 1, 0, "R6 locked status write");
        do_cmd(8'h01, 20'h0, 3'd2, 8'h04, 1, 1, "R7 two data bytes");
        do_cmd(8'h01, 20'h0, 3'd0, 8'h04, 1, 1, "R7 no data bytes");
        do_cmd(8'h01, 20'h0, 3'd1, 8'h04, 1, 1, "R6 pin high unlocks");
        drain("R9 status write to level 1");
        do_cmd(8'h06, 20'h0, 3'd0, 8'h00, 1, 1, "R2 set latch");
        do_cmd(8'hD8, 20'hF0000, 3'd0, 8'h00, 1, 1, "R4 sector in level 1 region");
        do_cmd(8'hC7, 20'h0, 3'd0, 8'h00, 1, 1, "R5 chip erase at level 1");
        do_cmd(8'h02, 20'hEFF00, 3'd0, 8'h00, 1, 1, "R7 program with no data");
        do_cmd(8'h03, 20'h0, 3'd0, 8'h00, 1, 1, "R10 unknown opcode");
        do_cmd(8'hD8, 20'hEFFFF, 3'd0, 8'h00, 1, 1, "R4 R8 sector below boundary");
        drain("R9 sector interval");
        do_cmd(8'h06, 20'h0, 3'd0, 8'h00, 1, 1, "R2 set latch");
        do_cmd(8'hD7, 20'hEFFFF, 3'd0, 8'h00, 1, 1, "R8 small sector below boundary");
        drain("R9 small sector interval");
        do_cmd(8'h06, 20'h0, 3'd0, 8'h00, 1, 1, "R2 set latch");
        do_cmd(8'h01, 20'h0, 3'd1, 8'h10, 1, 1, "R6 status write to level 4");
        drain("R9 status write interval");
        do_cmd(8'h06, 20'h0, 3'd0, 8'h00, 1, 1, "R2 set latch");
        do_cmd(8'h20, 20'h80000, 3'd0, 8'h00, 1, 1, "R4 level 4 lower edge");
        do_cmd(8'h02, 20'h7FF00, 3'd3, 8'h00, 1, 1, "R8 page below level 4 edge");
        drain("R9 program interval");
        do_cmd(8'h06, 20'h0, 3'd0, 8'h00, 1, 1, "R2 set latch");
        do_cmd(8'h01, 20'h0, 3'd1, 8'h00, 1, 1, "R6 back to level 0");
        drain("R9 status write interval");
        do_cmd(8'h06, 20'h0, 3'd0, 8'h00, 1, 1, "R2 set latch");
        do_cmd(8'hC7, 20'h0, 3'd0, 8'h00, 1, 1, "R5 chip erase at level 0");
        drain("R9 chip erase interval");

        for (int i = 0; i < 600; i++) begin
            int sel;
            bit [7:0] c;
            sel = int'($urandom % 12);
            if (m_busy && sel < 5) begin
                do_tick("R9 random tick");
            end else begin
                case (sel)
                    0, 1, 2: c = 8'h06;
                    3:       c = 8'h04;
                    4:       c = 8'h01;
                    5:       c = 8'h20;
                    6:       c = 8'hD7;
                    7:       c = 8'hD8;
                    8:       c = 8'hC7;
                    9:       c = 8'h02;
                    10:      c = 8'h9F;
                    default: c = 8'h02;
                endcase
                do_cmd(c, 20'($urandom), 3'($urandom % 3), 8'($urandom),
                       ($urandom % 10) != 0, 1'($urandom), "R3 R10 random command");
            end
        end
        drain("R9 final drain");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R9 watchdog expired actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule